// File: doc/BRIEF.md
# Conditional trap evaluation unit

This unit sits beside the integer pipeline of a 64-bit processor and decides whether a conditional trap instruction is taken. Each cycle it may receive one instruction word with a valid strobe, together with the values of the two source registers. If the word is one of the four conditional trap forms, the unit compares the first operand with the second. The second operand is either the other register or a 16-bit immediate taken from the instruction and sign-extended.

A 5-bit condition mask in the instruction selects which relations count: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. Any combination of them may be enabled. The trap is taken when at least one enabled relation holds. Word forms look only at the low 32 bits of each operand, and doubleword forms use all 64 bits.

A taken trap raises a registered program-interrupt request one cycle after the strobe. It also presents a 64-bit cause word for the saved-status register, with only the trap cause bit set. Operand fetch, program-counter redirection and other exception classes are handled elsewhere.

Top module: `trap_eval_unit`

## Requirements
- R1: The condition mask is instruction bits 25:21 (bit 0 is the LSB). Mask bit 4 (0x10) enables signed a<b, bit 3 (0x08) signed a>b, bit 2 (0x04) a==b, bit 1 (0x02) unsigned a<b and bit 0 (0x01) unsigned a>b. The trap is taken when the OR over all mask bits of (mask bit AND its relation) is 1.
- R2: Instruction bits 31:26 are the primary opcode. Primary opcode 3 is the word-immediate form and 2 is the doubleword-immediate form. Under primary opcode 31, bits 10:1 equal to 4 select the word register form and 68 the doubleword register form. Every other encoding never traps.
- R3: Word forms compare only bits 31:0 of each operand, so operand bits 63:32 have no effect on the result.
- R4: Doubleword forms compare all 64 bits of both operands.
- R5: Immediate forms take b from instruction bits 15:0, sign-extended to 64 bits, and ignore the second register operand.
- R6: When the trap request is 1, the cause word equals 0x0000_0000_0001_0000: bit 16 set, and every other bit clear, including bits 17 and 18. When the request is 0, the cause word is zero.
- R7: A mask of 0 never traps. A mask of 0x1F always traps for any trap form.
- R8: Outputs are registered. The request reflects the instruction presented with the strobe at the previous rising clock edge. It is 0 after any cycle whose strobe is low.
- R9: An asynchronous active-low reset clears the request and the cause word at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and operands are valid this cycle |
| instr_i | input | 32 | Instruction word |
| opa_i | input | 64 | First register operand |
| opb_i | input | 64 | Second register operand |
| trap_o | output | 1 | Registered trap request |
| cause_o | output | 64 | Registered saved-status cause word |

## Verification
All 32 mask values are crossed with eight operand pairs in each of the four instruction forms. The pairs are equal values, values that differ only in the 64-bit or the 32-bit sign bit, extreme positive and negative numbers, and a pair whose upper halves differ while the lower halves match. These pairs separate signed from unsigned ordering and show that word forms ignore the upper half. Immediate forms are driven with a misleading second register, which shows that the immediate is used and sign-extended. Directed cases cover a dropped strobe, near-miss opcodes and reset, both before any traffic and while a trap is being reported.

// File: rtl/trap_pkg.sv
package trap_pkg;
  parameter int XLEN      = 64;
  parameter int WLEN      = 32;
  parameter int ILEN      = 32;
  parameter int CONDW     = 5;
  parameter int CAUSE_BIT = 16;

  // relation positions inside the condition vector (match mask bits)
  localparam int C_UGT = 0;
  localparam int C_ULT = 1;
  localparam int C_EQ  = 2;
  localparam int C_SGT = 3;
  localparam int C_SLT = 4;

  localparam logic [5:0] PO_TWI = 6'd3;
  localparam logic [5:0] PO_TDI = 6'd2;
  localparam logic [5:0] PO_EXT = 6'd31;
  localparam logic [9:0] XO_TW  = 10'd4;
  localparam logic [9:0] XO_TD  = 10'd68;

  typedef struct packed {
    logic hit;   // a conditional trap form
    logic word;  // 32-bit comparison
    logic imm;   // second operand is the immediate
  } trap_dec_t;
endpackage

// File: rtl/trap_decode.sv
module trap_decode
  import trap_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  logic [ILEN-1:0]  instr_i,
  output trap_dec_t        dec_o,
  output logic [CONDW-1:0] mask_o,
  output logic [DW-1:0]    imm_o
);
  logic [5:0] po;
  logic [9:0] xo;
  logic       unused_fields;

  assign po            = instr_i[31:26];
  assign xo            = instr_i[10:1];
  assign mask_o        = instr_i[25:21];
  assign imm_o         = {{(DW-16){instr_i[15]}}, instr_i[15:0]};
  assign unused_fields = ^{instr_i[20:16], instr_i[0]};

  always_comb begin
    dec_o = '0;
    case (po)
      PO_TWI: dec_o = '{hit: 1'b1, word: 1'b1, imm: 1'b1};
      PO_TDI: dec_o = '{hit: 1'b1, word: 1'b0, imm: 1'b1};
      PO_EXT: begin
        if (xo == XO_TW)      dec_o = '{hit: 1'b1, word: 1'b1, imm: 1'b0};
        else if (xo == XO_TD) dec_o = '{hit: 1'b1, word: 1'b0, imm: 1'b0};
      end
      default: dec_o = '0;
    endcase
  end
endmodule

// File: rtl/trap_cmp.sv
module trap_cmp
  import trap_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic [CONDW-1:0] cond_o
);
  always_comb begin
    cond_o        = '0;
    cond_o[C_SLT] = $signed(a_i) < $signed(b_i);
    cond_o[C_SGT] = $signed(a_i) > $signed(b_i);
    cond_o[C_EQ]  = a_i == b_i;
    cond_o[C_ULT] = a_i < b_i;
    cond_o[C_UGT] = a_i > b_i;
  end

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      // R1
      signed_order_chk: assert ($onehot({cond_o[C_SLT], cond_o[C_SGT], cond_o[C_EQ]}));
      // R1
      unsigned_order_chk: assert ($onehot({cond_o[C_ULT], cond_o[C_UGT], cond_o[C_EQ]}));
    end
  end
endmodule

// File: rtl/trap_eval_unit.sv
module trap_eval_unit
  import trap_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic            trap_o,
  output logic [XLEN-1:0] cause_o
);
  localparam logic [XLEN-1:0] CAUSE_WORD = XLEN'(1) << CAUSE_BIT;
  localparam int NWID = 2;

  trap_dec_t        dec;
  logic [CONDW-1:0] mask;
  logic [XLEN-1:0]  imm64;
  logic [XLEN-1:0]  opb_sel;
  logic [CONDW-1:0] cond_by_w [NWID];
  logic [CONDW-1:0] cond;
  logic             fire;
  logic             en;
  logic             trap_d, trap_q;
  logic [XLEN-1:0]  cause_d, cause_q;

  trap_decode #(.DW(XLEN)) u_dec (
    .instr_i (instr_i),
    .dec_o   (dec),
    .mask_o  (mask),
    .imm_o   (imm64)
  );

  assign opb_sel = dec.imm ? imm64 : opb_i;

  // index 0: word comparator, index 1: doubleword comparator
  for (genvar g = 0; g < NWID; g++) begin : g_cmp
    localparam int GW = (g == 0) ? WLEN : XLEN;
    trap_cmp #(.W(GW)) u_cmp (
      .a_i    (opa_i[GW-1:0]),
      .b_i    (opb_sel[GW-1:0]),
      .cond_o (cond_by_w[g])
    );
  end

  assign cond = dec.word ? cond_by_w[0] : cond_by_w[1];
  assign fire = valid_i & dec.hit & (|(mask & cond));
  assign en   = valid_i | trap_q;

  always_comb begin
    trap_d  = trap_q;
    cause_d = cause_q;
    if (en) begin
      trap_d  = fire;
      cause_d = fire ? CAUSE_WORD : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      trap_q  <= trap_d;
      cause_q <= cause_d;
    end
  end

  assign trap_o  = trap_q;
  assign cause_o = cause_q;

  // R6
  cause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (cause_o[CAUSE_BIT] && $countones(cause_o) == 1));
  // R6
  cause_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> (cause_o == '0));
  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !trap_o);
  // R2
  foreign_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dec.hit) |=> !trap_o);
  // R7
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[25:21] == 5'h00) |=> !trap_o);
  // R7
  full_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dec.hit && instr_i[25:21] == 5'h1f) |=> trap_o);
endmodule

// File: tb/sim_trap_eval_unit.sv
module sim_trap_eval_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic        trap_o;
  logic [63:0] cause_o;

  trap_eval_unit u0 (
    .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (valid_i), .instr_i (instr_i),
    .opa_i (opa_i), .opb_i (opb_i), .trap_o (trap_o), .cause_o (cause_o)
  );

  always #4 clk_i = ~clk_i;

  // relation vector order {slt, sgt, eq, ult, ugt}; cd = 64-bit, cw = 32-bit
  typedef struct packed {
    logic [63:0] a;
    logic [15:0] imm;
    logic [4:0]  cd;
    logic [4:0]  cw;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{64'h0000_0000_0000_0005, 16'h0005, 5'b00100, 5'b00100},
    '{64'h8000_0000_0000_0000, 16'h0000, 5'b10001, 5'b00100},
    '{64'h7FFF_FFFF_FFFF_FFFF, 16'hFFFF, 5'b01010, 5'b00100},
    '{64'h0000_0000_8000_0000, 16'h0000, 5'b01001, 5'b10001},
    '{64'hFFFF_FFFF_0000_0005, 16'h0005, 5'b10001, 5'b00100},
    '{64'h0000_0000_0000_0001, 16'h8000, 5'b01010, 5'b01010},
    '{64'h8000_0000_0000_0000, 16'h7FFF, 5'b10001, 5'b10010},
    '{64'hFFFF_FFFF_FFFF_FFFE, 16'hFFFF, 5'b10010, 5'b10010}
  };

  localparam logic [63:0] CAUSE_EXP = 64'h0000_0000_0001_0000;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(input int form, input logic [4:0] m, input logic [15:0] imm);
    case (form)
      0:       return {6'd3, m, 5'd1, imm};
      1:       return {6'd2, m, 5'd1, imm};
      2:       return {6'd31, m, 5'd1, 5'd2, 10'd4, 1'b0};
      default: return {6'd31, m, 5'd1, 5'd2, 10'd68, 1'b0};
    endcase
  endfunction

  // drive at a falling edge, check at the next falling edge
  task automatic apply(input logic v, input logic [31:0] ins, input logic [63:0] a,
                       input logic [63:0] b, input logic exp_trap, input string tag);
    valid_i = v; instr_i = ins; opa_i = a; opb_i = b;
    @(negedge clk_i);
    check({tag, " trap"}, {63'd0, trap_o}, {63'd0, exp_trap});
    check("R6 cause", cause_o, exp_trap ? CAUSE_EXP : 64'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        nerr++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        summary();
        $finish;
      end
    end
  end

  initial begin
    // R9 reset state
    repeat (2) @(negedge clk_i);
    check("R9 reset trap", {63'd0, trap_o}, 64'd0);
    check("R9 reset cause", cause_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // main sweep: R1 with R3/R4 (width) and R5 (immediate), R7 at mask 0 and 0x1F
    for (int f = 0; f < 4; f++) begin
      for (int v = 0; v < NV; v++) begin
        for (int m = 0; m < 32; m++) begin
          logic [4:0]  cnd;
          logic [63:0] b;
          logic        immf;
          string       tg;
          immf = (f < 2);
          cnd  = (f == 0 || f == 2) ? VEC[v].cw : VEC[v].cd;
          b    = {{48{VEC[v].imm[15]}}, VEC[v].imm};
          if (m == 0 || m == 31)      tg = "R7";
          else if (immf)              tg = "R1 R5";
          else if (f == 2)            tg = "R1 R3";
          else                        tg = "R1 R4";
          // immediate forms get a second register that would flip every relation
          apply(1'b1, mk_instr(f, 5'(m), VEC[v].imm), VEC[v].a,
                immf ? ~b : b, |(5'(m) & cnd), tg);
        end
      end
    end

    // R3: upper halves differ wildly, low halves equal
    apply(1'b1, mk_instr(2, 5'h04, 16'h0), 64'h1234_5678_0000_00AA,
          64'h8765_4321_0000_00AA, 1'b1, "R3 upper ignored");
    // R4: only bit 40 differs, doubleword sees unsigned greater
    apply(1'b1, mk_instr(3, 5'h01, 16'h0), 64'h0000_0100_0000_0000,
          64'h0, 1'b1, "R4 high bit");
    // R8: strobe low with a full mask must not trap
    apply(1'b0, mk_instr(0, 5'h1F, 16'h0), 64'd0, 64'd0, 1'b0, "R8 no strobe");
    apply(1'b1, mk_instr(1, 5'h1F, 16'h0), 64'd0, 64'd0, 1'b1, "R8 strobe");
    apply(1'b0, mk_instr(1, 5'h1F, 16'h0), 64'd0, 64'd0, 1'b0, "R8 drop after trap");
    // R2: near-miss encodings never trap
    apply(1'b1, {6'd31, 5'h1F, 5'd1, 5'd2, 10'd5, 1'b0}, 64'd0, 64'd0, 1'b0, "R2 xo 5");
    apply(1'b1, {6'd31, 5'h1F, 5'd1, 5'd2, 10'd69, 1'b0}, 64'd0, 64'd0, 1'b0, "R2 xo 69");
    apply(1'b1, {6'd14, 5'h1F, 5'd1, 16'h0}, 64'd0, 64'd0, 1'b0, "R2 po 14");
    apply(1'b1, {6'd1, 5'h1F, 5'd1, 16'h0}, 64'd0, 64'd0, 1'b0, "R2 po 1");

    // R9: reset while a trap is reported clears outputs immediately
    apply(1'b1, mk_instr(2, 5'h04, 16'h0), 64'd7, 64'd7, 1'b1, "R9 pre");
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    #1;
    check("R9 async trap", {63'd0, trap_o}, 64'd0);
    check("R9 async cause", cause_o, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 after release", {63'd0, trap_o}, 64'd0);

    summary();
    $finish;
  end
endmodule